// File: doc/BRIEF.md
# Encoded Bus Clock Prescaler

This block derives a slower bus rate from a fast system clock. A 4-bit selector picks the division ratio from a non-linear map. Any selector with its top bit clear runs the bus at the full system rate. The other eight selectors step through powers of two, from 2 up to 512, and the ratio 32 is left out.

The block does not gate or generate a real clock. It issues a one-cycle enable strobe (`tick_o`) once per divided period, which downstream logic uses to qualify its registers. It also drives a square-wave copy of the divided rate (`clk_div_o`) for observation, and reports the ratio currently in force (`div_ratio_o`).

The selector may change at any time. A new value is adopted only at the end of the period in progress, so no shortened period appears. As an example, with a 72 MHz system clock, selector 1011 gives a 4.5 MHz strobe and selector 1111 gives 140.625 kHz.

Top module: `bus_prescaler`

## Requirements
- R1: When `div_code[3]` is 0, the active ratio is 1 and `tick_o` is high in every cycle after reset.
- R2: Selectors 1000, 1001, 1010 and 1011 give active ratios 2, 4, 8 and 16.
- R3: Selectors 1100, 1101, 1110 and 1111 give active ratios 64, 128, 256 and 512, and `div_ratio_o` never reads 32.
- R4: For an active ratio N of 2 or more, `tick_o` is high for exactly one cycle out of every N consecutive cycles.
- R5: A selector change is adopted only in the cycle after a `tick_o` cycle (a period boundary), and the period in progress completes at its old length.
- R6: Synchronous reset clears the period count and adopts the selector present during reset. The first `tick_o` appears in the N-th cycle counted from the first cycle after the last reset edge.
- R7: `div_ratio_o` reports the ratio in force as a plain binary number (1 to 512), not a pending selector.
- R8: `clk_div_o` is high during the first N/2 cycles of each period and low during the remaining N/2. In pass-through it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Division selector |
| tick_o | output | 1 | One-cycle enable at the divided rate |
| clk_div_o | output | 1 | Square wave at the divided rate |
| div_ratio_o | output | 10 | Ratio currently in force |

## Verification
A wrong period count shows on `tick_o` and `clk_div_o` within one divided period: the strobe lands early or late, or the square wave's duty cycle drifts. A wrong held ratio shows on `div_ratio_o` in the very cycle it is adopted. A boundary slip, where a selector is taken mid-period, appears as a changed `div_ratio_o` in a cycle that did not follow a strobe. The bench keeps a behavioural counter and compares all three outputs every cycle. It also checks reset latency, mid-period selector changes, pass-through, and every selector value.

// File: rtl/bpre_pkg.sv
package bpre_pkg;
    localparam int CODE_W  = 4;
    localparam int SHIFT_W = 4;
    localparam int RATIO_W = 10;
    localparam int LOW_W   = CODE_W - 1;
    localparam int GAP_AT  = 1 << (LOW_W - 1);

    typedef logic [SHIFT_W-1:0] shift_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic   pass;
        shift_t shift;
    } sel_t;

    function automatic sel_t decode_sel(input logic [CODE_W-1:0] code);
        sel_t s;
        logic [LOW_W-1:0] low;
        low = code[LOW_W-1:0];
        s.pass  = ~code[CODE_W-1];
        if (s.pass)
            s.shift = '0;
        else if (int'(low) >= GAP_AT)
            s.shift = SHIFT_W'(int'(low) + 2);
        else
            s.shift = SHIFT_W'(int'(low) + 1);
        return s;
    endfunction
endpackage

// File: rtl/bpre_decode.sv
module bpre_decode
    import bpre_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output shift_t            shift_o
);
    sel_t sel;
    always_comb begin
        sel     = decode_sel(code_i);
        shift_o = sel.shift;
    end

    always_comb begin
        if (!code_i[CODE_W-1]) assert (shift_o == '0);
    end
endmodule

// File: rtl/bpre_counter.sv
module bpre_counter
    import bpre_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  shift_t nxt_shift_i,
    output shift_t act_shift_o,
    output ratio_t cnt_o,
    output logic   tick_o
);
    ratio_t ratio;
    ratio_t cnt_q;
    shift_t act_q;

    always_comb begin
        ratio  = RATIO_W'(1) << act_q;
        tick_o = (cnt_q == ratio - RATIO_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= nxt_shift_i;
        end else if (tick_o) begin
            cnt_q <= '0;
            act_q <= nxt_shift_i;
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end

    assign act_shift_o = act_q;
    assign cnt_o       = cnt_q;

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio);
    p_wrap_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0));
    p_shift_held_r5: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(act_q));
endmodule

// File: rtl/bpre_shape.sv
module bpre_shape
    import bpre_pkg::*;
(
    input  shift_t act_shift_i,
    input  ratio_t cnt_i,
    output logic   clk_div_o,
    output ratio_t ratio_o
);
    ratio_t half;
    always_comb begin
        ratio_o   = RATIO_W'(1) << act_shift_i;
        half      = ratio_o >> 1;
        clk_div_o = (act_shift_i == '0) ? 1'b1 : (cnt_i < half);
    end
endmodule

// File: rtl/bus_prescaler.sv
module bus_prescaler
    import bpre_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  div_code,
    output logic               tick_o,
    output logic               clk_div_o,
    output logic [RATIO_W-1:0] div_ratio_o
);
    shift_t nxt_shift;
    shift_t act_shift;
    ratio_t cnt;

    bpre_decode u_dec (
        .code_i  (div_code),
        .shift_o (nxt_shift)
    );

    bpre_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .nxt_shift_i (nxt_shift),
        .act_shift_o (act_shift),
        .cnt_o       (cnt),
        .tick_o      (tick_o)
    );

    bpre_shape u_shp (
        .act_shift_i (act_shift),
        .cnt_i       (cnt),
        .clk_div_o   (clk_div_o),
        .ratio_o     (div_ratio_o)
    );

    p_pass_tick_r1: assert property (@(posedge clk) disable iff (rst)
        (div_ratio_o == RATIO_W'(1)) |-> tick_o);
    p_ratio_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot(div_ratio_o));
    p_no_div32_r3: assert property (@(posedge clk) disable iff (rst)
        div_ratio_o != RATIO_W'(32));
    p_ratio_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(div_ratio_o));
endmodule

// File: tb/test_bus_prescaler.sv
module test_bus_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] div_code = 4'b1010;
    logic       tick_o;
    logic       clk_div_o;
    logic [9:0] div_ratio_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int m_ratio = 1;
    int m_cnt   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bus_prescaler i_bus_prescaler (
        .clk(clk), .rst(rst), .div_code(div_code),
        .tick_o(tick_o), .clk_div_o(clk_div_o), .div_ratio_o(div_ratio_o)
    );

    function automatic int exp_ratio(input logic [3:0] c);
        case (c)
            4'b1000: return 2;
            4'b1001: return 4;
            4'b1010: return 8;
            4'b1011: return 16;
            4'b1100: return 64;
            4'b1101: return 128;
            4'b1110: return 256;
            4'b1111: return 512;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ratio = exp_ratio(div_code);
            m_cnt   = 0;
        end else if (m_cnt == m_ratio - 1) begin
            m_ratio = exp_ratio(div_code);
            m_cnt   = 0;
        end else begin
            m_cnt++;
        end
        if (cyc > 150000 && !done) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst && cyc > 0) begin
            chk(tick_o == (m_cnt == m_ratio - 1), "R4 tick", tick_o, m_cnt == m_ratio - 1);
            chk(int'(div_ratio_o) == m_ratio, "R7 ratio", div_ratio_o, m_ratio);
            chk(clk_div_o == ((m_ratio == 1) ? 1'b1 : (m_cnt < m_ratio / 2)),
                "R8 clk_div", clk_div_o, (m_ratio == 1) ? 1 : int'(m_cnt < m_ratio / 2));
        end
    end

    task automatic settle(input int exp);
        for (int k = 0; k < 1200 && int'(div_ratio_o) != exp; k++) @(negedge clk);
    endtask

    task automatic wait_tick();
        for (int k = 0; k < 1200 && !tick_o; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tick_o == 1'b0, "R6 reset tick", tick_o, 0);
        chk(div_ratio_o == 10'd8, "R6 reset ratio", div_ratio_o, 8);
        rst = 1'b0;
        // R6: first strobe in the 8th cycle after the last reset edge
        begin
            int n;
            n = 1;
            while (!tick_o && n < 50) begin
                @(negedge clk);
                n++;
            end
            chk(n == 8, "R6 first tick", n, 8);
        end

        // R1, R2, R3: every selector value, with period measured between strobes
        for (int c = 0; c < 16; c++) begin
            int e, p;
            div_code = 4'(c);
            e = exp_ratio(4'(c));
            settle(e);
            chk(int'(div_ratio_o) == e, (c < 8) ? "R1 ratio" : (c < 12 ? "R2 ratio" : "R3 ratio"),
                div_ratio_o, e);
            wait_tick();
            @(negedge clk);
            p = 1;
            while (!tick_o && p < 1200) begin
                @(negedge clk);
                p++;
            end
            chk(p == e, (c < 12) ? "R2 period" : "R3 period", p, e);
        end

        // R1 and R8: pass-through holds the strobe and square wave high
        div_code = 4'b0101;
        settle(1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(tick_o == 1'b1, "R1 tick high", tick_o, 1);
            chk(clk_div_o == 1'b1, "R8 pass high", clk_div_o, 1);
        end

        // R5 and R7: mid-period change waits for the boundary
        div_code = 4'b1111;
        settle(512);
        wait_tick();
        repeat (5) @(negedge clk);
        div_code = 4'b1000;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            chk(div_ratio_o == 10'd512, "R7 held ratio", div_ratio_o, 512);
        end
        wait_tick();
        @(negedge clk);
        chk(div_ratio_o == 10'd2, "R5 adopt at boundary", div_ratio_o, 2);
        chk(tick_o == 1'b0, "R5 new period start", tick_o, 0);

        // R6: reset in mid-period restarts the count
        div_code = 4'b1001;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        begin
            int n;
            n = 1;
            while (!tick_o && n < 50) begin
                @(negedge clk);
                n++;
            end
            chk(n == 4, "R6 restart tick", n, 4);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule